// File: doc/BRIEF.md
# Receive Data-Rate and Signal-Strength Qualifier

This block tells a radio receiver's host whether a wanted transmission is being received. It applies two tests at the same time. The first test times the sliced receive data. It counts reference-clock cycles between successive transitions and checks that each interval lies inside a programmed window. The second test compares a 6-bit signal-strength sample against a programmed threshold.

When both tests pass and the self-polling operating mode is selected, the block pulls its active-low valid output low. A host can use that output as a wake-up interrupt. The window bounds, the strength threshold and the mode select are plain inputs held by surrounding logic. The reference clock is the receiver's crystal clock, nominally 18 MHz.

Top module: `rx_valid_detect`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the interval counter, the rate flag and the strength flag, and drives `validN` high from the next edge.
- R2: `rxDataAsync` passes through a two-stage synchroniser. Rising and falling transitions both end the current interval. The interval value compared at a transition equals the number of clock cycles since the previous transition.
- R3: The rate condition is true only if the measured interval is strictly greater than `rateLowBound` and strictly less than `rateHighBound`. An interval equal to either bound fails.
- R4: The interval counter stops at its all-ones value (255 by default) and does not wrap. A saturated count fails the rate test. When no transition arrives before saturation, the rate condition is cleared.
- R5: The first transition after reset only starts a measurement. It never sets the rate condition.
- R6: The strength condition is `rssiLevel >= rssiThreshold`, with both treated as 6-bit unsigned values. It is sampled on every clock.
- R7: `validN` is registered. It is low only when the rate condition and the strength condition are both true. `validN` is low for valid and high for not valid.
- R8: While `pollModeEn` is low, `validN` is held high whatever the two conditions are.
- R9: The rate condition is re-evaluated only when a transition closes an interval. A change to the bounds between transitions leaves `validN` unchanged until the next transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock, used as the timebase |
| rst | input | 1 | Synchronous reset, active high |
| rxDataAsync | input | 1 | Sliced receive data, asynchronous to `clk` |
| rssiLevel | input | 6 | Signal-strength sample, unsigned |
| rssiThreshold | input | 6 | Minimum strength accepted |
| rateLowBound | input | 8 | Interval must exceed this count |
| rateHighBound | input | 8 | Interval must stay below this count |
| pollModeEn | input | 1 | High selects self-polling mode, which enables the output |
| validN | output | 1 | Active-low valid indication |

## Verification
The hardest situation to reach is a rate verdict that sits exactly on a window edge. The same applies to a verdict that has to outlive a change of bounds between transitions. Both depend on how the data toggles line up with clock cycles.

The bench drives every data toggle on a falling clock edge, a chosen number of cycles after the previous toggle. Each interval is therefore known exactly. Directed cases place the interval on each bound, one cycle inside each bound, and beyond saturation. Random cases mix intervals, bounds, thresholds and mode.

// File: rtl/rx_valid_pkg.sv
package rx_valid_pkg;

  // Observations from the datapath to the control
  typedef struct packed {
    logic edgeSeen;   // a synchronised transition occurred this cycle
    logic inWindow;   // current count strictly between the bounds
    logic saturated;  // counter at its all-ones value
    logic ampOk;      // registered strength comparison
  } dvStatus_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic restart;    // load the counter with one
    logic run;        // allow the counter to advance
  } dvStrobe_t;

endpackage

// File: rtl/rx_valid_datapath.sv
module rx_valid_datapath
  import rx_valid_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int RSSI_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxDataAsync,
  input  logic [RSSI_W-1:0] rssiLevel,
  input  logic [RSSI_W-1:0] rssiThreshold,
  input  logic [CNT_W-1:0]  rateLowBound,
  input  logic [CNT_W-1:0]  rateHighBound,
  input  dvStrobe_t         strobe,
  output dvStatus_t         status
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // Synchroniser chain; stage 0 captures the asynchronous input
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   dataPrev;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncChain[g] <= 1'b0;
          else     syncChain[g] <= rxDataAsync;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncChain[g] <= 1'b0;
          else     syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dataPrev <= 1'b0;
    else     dataPrev <= syncChain[SYNC_STAGES-1];
  end

  logic edgeSeen;
  assign edgeSeen = syncChain[SYNC_STAGES-1] ^ dataPrev;

  // Interval counter, saturating
  logic [CNT_W-1:0] intervalCnt;

  always_ff @(posedge clk) begin
    if (rst)
      intervalCnt <= '0;
    else if (strobe.restart)
      intervalCnt <= CNT_ONE;
    else if (strobe.run && (intervalCnt != CNT_MAX))
      intervalCnt <= intervalCnt + CNT_ONE;
  end

  logic saturated;
  logic inWindow;
  assign saturated = (intervalCnt == CNT_MAX);
  assign inWindow  = (intervalCnt > rateLowBound) &&
                     (intervalCnt < rateHighBound) && !saturated;

  // Strength comparison, registered every clock
  logic ampOkQ;
  always_ff @(posedge clk) begin
    if (rst) ampOkQ <= 1'b0;
    else     ampOkQ <= (rssiLevel >= rssiThreshold);
  end

  always_comb begin
    status.edgeSeen  = edgeSeen;
    status.inWindow  = inWindow;
    status.saturated = saturated;
    status.ampOk     = ampOkQ;
  end

  // R4: counter holds at all-ones unless restarted
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (saturated && !strobe.restart) |=> (intervalCnt == CNT_MAX));

  // R2: a restart begins the next interval at one
  a_r2_restart_one: assert property (@(posedge clk) disable iff (rst)
    strobe.restart |=> (intervalCnt == CNT_ONE));

  // R6: the strength flag follows the previous cycle's comparison
  a_r6_amp_sample: assert property (@(posedge clk) disable iff (rst)
    (rssiLevel >= rssiThreshold) |=> ampOkQ);

endmodule

// File: rtl/rx_valid_ctrl.sv
module rx_valid_ctrl
  import rx_valid_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pollModeEn,
  input  dvStatus_t status,
  output dvStrobe_t strobe,
  output logic      validN
);

  logic armed;
  logic rateOk;

  // The first transition only arms the measurement
  always_ff @(posedge clk) begin
    if (rst)                  armed <= 1'b0;
    else if (status.edgeSeen) armed <= 1'b1;
  end

  always_comb begin
    strobe.restart = status.edgeSeen;
    strobe.run     = armed;
  end

  // The rate verdict is taken once per closed interval
  always_ff @(posedge clk) begin
    if (rst)
      rateOk <= 1'b0;
    else if (status.edgeSeen)
      rateOk <= armed && status.inWindow;
    else if (status.saturated)
      rateOk <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) validN <= 1'b1;
    else     validN <= !(pollModeEn && rateOk && status.ampOk);
  end

  // R1: reset forces the output inactive and clears the verdict
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (validN && !rateOk));

  // R5: no rate pass before a reference transition has been seen
  a_r5_armed_first: assert property (@(posedge clk) disable iff (rst)
    rateOk |-> armed);

  // R4: a timed-out interval drops the verdict
  a_r4_sat_clear: assert property (@(posedge clk) disable iff (rst)
    (status.saturated && !status.edgeSeen) |=> !rateOk);

  // R8: outside self-polling the output stays high
  a_r8_mode_idle: assert property (@(posedge clk) disable iff (rst)
    !pollModeEn |=> validN);

  // R7: a low output needs both conditions in the cycle before
  a_r7_both_needed: assert property (@(posedge clk) disable iff (rst)
    !validN |-> ($past(rateOk) && $past(status.ampOk)));

endmodule

// File: rtl/rx_valid_detect.sv
module rx_valid_detect
  import rx_valid_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int RSSI_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxDataAsync,
  input  logic [RSSI_W-1:0] rssiLevel,
  input  logic [RSSI_W-1:0] rssiThreshold,
  input  logic [CNT_W-1:0]  rateLowBound,
  input  logic [CNT_W-1:0]  rateHighBound,
  input  logic              pollModeEn,
  output logic              validN
);

  dvStatus_t status;
  dvStrobe_t strobe;

  rx_valid_datapath #(
    .CNT_W      (CNT_W),
    .RSSI_W     (RSSI_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .rxDataAsync  (rxDataAsync),
    .rssiLevel    (rssiLevel),
    .rssiThreshold(rssiThreshold),
    .rateLowBound (rateLowBound),
    .rateHighBound(rateHighBound),
    .strobe       (strobe),
    .status       (status)
  );

  rx_valid_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pollModeEn(pollModeEn),
    .status    (status),
    .strobe    (strobe),
    .validN    (validN)
  );

endmodule

// File: tb/test_rx_valid_detect.sv
module test_rx_valid_detect;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxData = 1'b0;
  logic [5:0] rssi = '0;
  logic [5:0] thr = '0;
  logic [7:0] lo = '0;
  logic [7:0] hi = '0;
  logic       poll = 1'b0;
  logic       validN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rx_valid_detect i_rx_valid_detect (
    .clk          (clk),
    .rst          (rst),
    .rxDataAsync  (rxData),
    .rssiLevel    (rssi),
    .rssiThreshold(thr),
    .rateLowBound (lo),
    .rateHighBound(hi),
    .pollModeEn   (poll),
    .validN       (validN)
  );

  function automatic logic expValid(int p, int l, int h, int r, int t, bit m);
    bit rateGood;
    rateGood = (p > l) && (p < h) && (p < 255);
    return !(m && rateGood && (r >= t));
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: validN=%b expected %b", req, act, exp);
    end
  endtask

  task automatic toggleAfter(int p);
    repeat (p) @(negedge clk);
    rxData = ~rxData;
  endtask

  // three toggles P apart, then let the pipeline settle
  task automatic burst(int p);
    toggleAfter(p);
    toggleAfter(p);
    toggleAfter(p);
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int p;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", validN, 1'b1);
    rst = 1'b0;

    // R5: a single transition after reset sets nothing
    poll = 1; lo = 5; hi = 50; rssi = 40; thr = 10;
    toggleAfter(10);
    repeat (4) @(negedge clk);
    check("R5", validN, 1'b1);
    // R2 R7: second transition closes a 10-cycle interval inside the window
    toggleAfter(10);
    repeat (4) @(negedge clk);
    check("R2", validN, 1'b0);

    // R9: raise the low bound between transitions; verdict held
    lo = 30;
    repeat (3) @(negedge clk);
    check("R9", validN, 1'b0);
    // next transition applies the new bound
    toggleAfter(5);
    repeat (4) @(negedge clk);
    check("R9", validN, 1'b1);

    // R3: interval equal to each bound fails, one inside passes
    lo = 12; hi = 20;
    burst(12); check("R3", validN, 1'b1);
    burst(13); check("R3", validN, 1'b0);
    burst(20); check("R3", validN, 1'b1);
    burst(19); check("R3", validN, 1'b0);

    // R6: strength equal to threshold passes, one below fails
    thr = 40; rssi = 40;
    repeat (3) @(negedge clk);
    check("R6", validN, 1'b0);
    rssi = 39;
    repeat (3) @(negedge clk);
    check("R6", validN, 1'b1);
    rssi = 63;

    // R8: self-polling off holds the output high
    poll = 0;
    repeat (3) @(negedge clk);
    check("R8", validN, 1'b1);
    poll = 1;
    repeat (3) @(negedge clk);
    check("R8", validN, 1'b0);

    // R4: no transition until saturation clears the verdict
    lo = 0; hi = 255;
    burst(100); check("R4", validN, 1'b0);
    repeat (300) @(negedge clk);
    check("R4", validN, 1'b1);
    // a saturated interval still fails at the transition
    toggleAfter(1);
    repeat (4) @(negedge clk);
    check("R4", validN, 1'b1);

    // R1: reset mid-run returns the output high
    burst(50); check("R4", validN, 1'b0);
    doReset();
    @(negedge clk);
    check("R1", validN, 1'b1);

    // random mix: R3 R6 R7 R8
    for (int i = 0; i < 60; i++) begin
      p    = 2 + int'($urandom_range(0, 60));
      lo   = 8'($urandom_range(0, 40));
      hi   = 8'($urandom_range(0, 70));
      rssi = 6'($urandom_range(0, 63));
      thr  = 6'($urandom_range(0, 63));
      poll = 1'($urandom_range(0, 3) != 0);
      burst(p);
      check("R7", validN, expValid(p, lo, hi, rssi, thr, poll));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule